// File: doc/BRIEF.md
# Mesh Vertex Sequencer with Output Writer

The sequencer steps through a two-dimensional grid of vertices and has an external microcode executor run its program once for each vertex. A one-cycle start strobe captures the base address of the output area and the last column and last row indices. The grid is then walked row by row. Within a row the column index climbs from zero to the last column, and the row index climbs from zero to the last row. Each vertex moves through a fixed chain of named states. In SETUP the current column and row appear on the coordinate outputs and a one-cycle program-counter clear goes to the executor. In RUN the executor runs, and the block counts the instructions it reports. The executor ends a vertex by raising a vector-output event that carries two 32-bit words.

The two words leave through a ready/valid write port, one after the other. WR_A sends the first word and WR_B sends the second. Each word is byte-reversed so that memory holds it most-significant byte first. Vertices sit on a fixed row pitch of 128 entries, with 8 bytes per entry. STEP moves the indices on to the next vertex, and DONE closes the run. In DONE the vertex count takes the product of the two loop exit values, and an interrupt pulses for one cycle before the block returns to IDLE. An instruction watchdog ends a run that never produces an output: the block goes from RUN straight to IDLE with an error flag set.

The transitions are as follows. IDLE goes to SETUP on start. SETUP goes to RUN unconditionally. RUN goes to WR_A on a vector output, or to IDLE when the watchdog trips. WR_A goes to WR_B on ready. WR_B goes to STEP on ready. STEP goes to DONE after the final vertex and back to SETUP otherwise. DONE goes to IDLE.

Top module: `mesh_seq`

## Requirements
- R1: After reset the block is idle: busy, interrupt, write-valid, error, vertex count and last-write address are all 0. A start strobe in idle sets busy on the next cycle, and busy stays high until the cycle after DONE.
- R2: A start strobe that arrives while busy has no effect. Base and last-index inputs that change during a run have no effect either, because all three are captured at start.
- R3: Vertices run with the row index as the outer loop and the column index as the inner loop, each from 0 to its captured last value inclusive. The current column and row are shown on coord_x_o and coord_y_o.
- R4: Before each vertex, pc_clear_o is high for exactly one cycle, and exec_run_o is high starting in the next cycle.
- R5: The first word goes to base + 8*(128*row + column) and the second word to that address + 4.
- R6: Write data is byte-reversed: bits 31:24 of mem_data_o carry bits 7:0 of the word, and so on through the bytes.
- R7: While mem_valid_o is high and mem_ready_i is low, mem_valid_o, mem_addr_o and mem_data_o stay unchanged. A word is done only when ready is seen.
- R8: After the second word of a vertex is accepted, last_dma_o holds that word's address (vertex address + 4).
- R9: If MAX_INSNS instruction steps arrive in one vertex with no vector output, the run stops. Busy falls, error_o goes to 1, no interrupt is issued and the vertex count is left as it was. Exactly MAX_INSNS-1 steps does not stop the run. The next start clears error_o.
- R10: At the end of a complete run, vtx_count_o becomes (last column + 1) * (last row + 1), and irq_o is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe; taken only in idle |
| base_i | input | ADDR_W | Base address of the output area |
| hlast_i | input | IDX_W | Last column index |
| vlast_i | input | IDX_W | Last row index |
| busy_o | output | 1 | Run in progress |
| coord_x_o | output | IDX_W | Current column for the executor |
| coord_y_o | output | IDX_W | Current row for the executor |
| pc_clear_o | output | 1 | Clears the executor program counter |
| exec_run_o | output | 1 | Executor may run |
| exec_step_i | input | 1 | One instruction executed |
| vout_i | input | 1 | Vector-output event |
| word_a_i | input | DATA_W | First output word |
| word_b_i | input | DATA_W | Second output word |
| mem_valid_o | output | 1 | Write request valid |
| mem_addr_o | output | ADDR_W | Write byte address |
| mem_data_o | output | DATA_W | Write data, byte-reversed |
| mem_ready_i | input | 1 | Write accepted |
| last_dma_o | output | ADDR_W | Address of the most recent second-word write |
| vtx_count_o | output | 2*(IDX_W+1) | Vertex count of the last complete run |
| error_o | output | 1 | Watchdog abort flag |
| irq_o | output | 1 | One-cycle completion pulse |

## Verification
The bench builds the block with IDX_W = 4 and MAX_INSNS = 16, and leaves the 128-entry pitch and 32-bit words at their defaults. The short instruction cap makes it cheap to drive the watchdog to exactly its limit and one step below it. The narrow index keeps random grids small while the row pitch still spreads addresses across many kilobytes. Random executor delays and ready stalls are mixed with single-vertex grids, start pokes during a run, and a restart after an abort.

// File: rtl/mseq_pkg.sv
package mseq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_RUN,
        ST_WR_A,
        ST_WR_B,
        ST_STEP,
        ST_DONE
    } mseq_state_e;

endpackage

// File: rtl/mseq_addr_gen.sv
module mseq_addr_gen #(
    parameter int IDX_W      = 7,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int ROW_PITCH  = 128,
    parameter int VERT_BYTES = 8
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [IDX_W-1:0]  x_i,
    input  logic [IDX_W-1:0]  y_i,
    output logic [ADDR_W-1:0] addr_a_o,
    output logic [ADDR_W-1:0] addr_b_o
);
    localparam logic [ADDR_W-1:0] ROW_BYTES  = ADDR_W'(ROW_PITCH * VERT_BYTES);
    localparam logic [ADDR_W-1:0] VTX_BYTES  = ADDR_W'(VERT_BYTES);
    localparam logic [ADDR_W-1:0] WORD_BYTES = ADDR_W'(DATA_W / 8);

    always_comb begin
        addr_a_o = base_i + (ADDR_W'(y_i) * ROW_BYTES) + (ADDR_W'(x_i) * VTX_BYTES);
        addr_b_o = addr_a_o + WORD_BYTES;
    end
endmodule

// File: rtl/mseq_wdog.sv
module mseq_wdog #(
    parameter int MAX_INSNS = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic en_i,
    input  logic step_i,
    output logic trip_o
);
    localparam int WD_W = (MAX_INSNS > 2) ? $clog2(MAX_INSNS) : 1;
    localparam logic [WD_W-1:0] LIMIT = WD_W'(MAX_INSNS - 1);

    logic [WD_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clear_i)
            cnt_q <= '0;
        else if (en_i && step_i && cnt_q != LIMIT)
            cnt_q <= cnt_q + 1'b1;
    end

    // the step that would be number MAX_INSNS trips the limit
    assign trip_o = en_i && step_i && (cnt_q == LIMIT);
endmodule

// File: rtl/mseq_bswap.sv
module mseq_bswap #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] in_i,
    output logic [DATA_W-1:0] out_o
);
    localparam int NBYTES = DATA_W / 8;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        assign out_o[8*i +: 8] = in_i[8*(NBYTES-1-i) +: 8];
    end
endmodule

// File: rtl/mesh_seq.sv
module mesh_seq
    import mseq_pkg::*;
#(
    parameter int IDX_W      = 7,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int ROW_PITCH  = 128,
    parameter int VERT_BYTES = 8,
    parameter int MAX_INSNS  = 2048
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [ADDR_W-1:0]         base_i,
    input  logic [IDX_W-1:0]          hlast_i,
    input  logic [IDX_W-1:0]          vlast_i,
    output logic                      busy_o,
    output logic [IDX_W-1:0]          coord_x_o,
    output logic [IDX_W-1:0]          coord_y_o,
    output logic                      pc_clear_o,
    output logic                      exec_run_o,
    input  logic                      exec_step_i,
    input  logic                      vout_i,
    input  logic [DATA_W-1:0]         word_a_i,
    input  logic [DATA_W-1:0]         word_b_i,
    output logic                      mem_valid_o,
    output logic [ADDR_W-1:0]         mem_addr_o,
    output logic [DATA_W-1:0]         mem_data_o,
    input  logic                      mem_ready_i,
    output logic [ADDR_W-1:0]         last_dma_o,
    output logic [2*(IDX_W+1)-1:0]    vtx_count_o,
    output logic                      error_o,
    output logic                      irq_o
);
    localparam int CNT_W = 2 * (IDX_W + 1);

    mseq_state_e state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [IDX_W-1:0]  hl_q, vl_q, x_q, y_q;
    logic [DATA_W-1:0] wa_q, wb_q;
    logic [ADDR_W-1:0] last_dma_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              err_q;

    logic [ADDR_W-1:0] addr_a, addr_b;
    logic [DATA_W-1:0] swap_a, swap_b;
    logic              wd_trip;
    logic              last_x, last_y;
    logic [CNT_W-1:0]  cols, rows;

    assign last_x = (x_q == hl_q);
    assign last_y = (y_q == vl_q);
    assign cols   = CNT_W'(hl_q) + CNT_W'(1);
    assign rows   = CNT_W'(vl_q) + CNT_W'(1);

    mseq_addr_gen #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .ROW_PITCH(ROW_PITCH), .VERT_BYTES(VERT_BYTES)
    ) u_addr (
        .base_i(base_q), .x_i(x_q), .y_i(y_q),
        .addr_a_o(addr_a), .addr_b_o(addr_b)
    );

    mseq_wdog #(.MAX_INSNS(MAX_INSNS)) u_wdog (
        .clk(clk), .rst_n(rst_n),
        .clear_i(state_q == ST_SETUP),
        .en_i(state_q == ST_RUN && !vout_i),
        .step_i(exec_step_i),
        .trip_o(wd_trip)
    );

    mseq_bswap #(.DATA_W(DATA_W)) u_swap_a (.in_i(wa_q), .out_o(swap_a));
    mseq_bswap #(.DATA_W(DATA_W)) u_swap_b (.in_i(wb_q), .out_o(swap_b));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_SETUP;
            ST_SETUP: state_d = ST_RUN;
            ST_RUN: begin
                if (vout_i)       state_d = ST_WR_A;
                else if (wd_trip) state_d = ST_IDLE;
            end
            ST_WR_A:  if (mem_ready_i) state_d = ST_WR_B;
            ST_WR_B:  if (mem_ready_i) state_d = ST_STEP;
            ST_STEP:  state_d = (last_x && last_y) ? ST_DONE : ST_SETUP;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != ST_IDLE);
        pc_clear_o  = (state_q == ST_SETUP);
        exec_run_o  = (state_q == ST_RUN);
        mem_valid_o = (state_q == ST_WR_A) || (state_q == ST_WR_B);
        mem_addr_o  = (state_q == ST_WR_B) ? addr_b : addr_a;
        mem_data_o  = (state_q == ST_WR_B) ? swap_b : swap_a;
        irq_o       = (state_q == ST_DONE);
        coord_x_o   = x_q;
        coord_y_o   = y_q;
        last_dma_o  = last_dma_q;
        vtx_count_o = cnt_q;
        error_o     = err_q;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q     <= '0;
            hl_q       <= '0;
            vl_q       <= '0;
            x_q        <= '0;
            y_q        <= '0;
            wa_q       <= '0;
            wb_q       <= '0;
            last_dma_q <= '0;
            cnt_q      <= '0;
            err_q      <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (start_i) begin
                    base_q <= base_i;
                    hl_q   <= hlast_i;
                    vl_q   <= vlast_i;
                    x_q    <= '0;
                    y_q    <= '0;
                    err_q  <= 1'b0;
                end
                ST_RUN: begin
                    if (vout_i) begin
                        wa_q <= word_a_i;
                        wb_q <= word_b_i;
                    end else if (wd_trip) begin
                        err_q <= 1'b1;
                    end
                end
                ST_WR_B: if (mem_ready_i) last_dma_q <= addr_b;
                ST_STEP: if (!(last_x && last_y)) begin
                    if (last_x) begin
                        x_q <= '0;
                        y_q <= y_q + 1'b1;
                    end else begin
                        x_q <= x_q + 1'b1;
                    end
                end
                ST_DONE: cnt_q <= cols * rows;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/mseq_chk.sv
module mseq_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_o,
    input logic              pc_clear_o,
    input logic              exec_run_o,
    input logic              mem_valid_o,
    input logic              mem_ready_i,
    input logic [ADDR_W-1:0] mem_addr_o,
    input logic [DATA_W-1:0] mem_data_o,
    input logic              error_o,
    input logic              irq_o
);
    // R4
    pc_clear_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_clear_o |=> (!pc_clear_o && exec_run_o));

    // R7
    write_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o && !mem_ready_i) |=>
            (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o)));

    // R10
    irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> (!irq_o && !busy_o));

    // R9
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error_o) |-> (!busy_o && !irq_o));

    // R1
    activity_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_valid_o || exec_run_o || pc_clear_o || irq_o) |-> busy_o);
endmodule

bind mesh_seq mseq_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy_o(busy_o), .pc_clear_o(pc_clear_o),
    .exec_run_o(exec_run_o), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
    .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .error_o(error_o), .irq_o(irq_o)
);

// File: tb/mesh_seq_test.sv
module mesh_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int IDX_W      = 4;
    localparam int ADDR_W     = 32;
    localparam int DATA_W     = 32;
    localparam int MAX_INSNS  = 16;
    localparam int CNT_W      = 2 * (IDX_W + 1);
    localparam int WDOG_LIMIT = 100000;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] base_i = '0;
    logic [IDX_W-1:0]  hlast_i = '0, vlast_i = '0;
    logic              busy_o, pc_clear_o, exec_run_o;
    logic [IDX_W-1:0]  coord_x_o, coord_y_o;
    logic              exec_step_i = 1'b0, vout_i = 1'b0;
    logic [DATA_W-1:0] word_a_i = '0, word_b_i = '0;
    logic              mem_valid_o, mem_ready_i = 1'b0;
    logic [ADDR_W-1:0] mem_addr_o, last_dma_o;
    logic [DATA_W-1:0] mem_data_o;
    logic [CNT_W-1:0]  vtx_count_o;
    logic              error_o, irq_o;

    int n_chk = 0;
    int n_bad = 0;
    int irq_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mesh_seq #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAX_INSNS(MAX_INSNS)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
        .hlast_i(hlast_i), .vlast_i(vlast_i), .busy_o(busy_o),
        .coord_x_o(coord_x_o), .coord_y_o(coord_y_o), .pc_clear_o(pc_clear_o),
        .exec_run_o(exec_run_o), .exec_step_i(exec_step_i), .vout_i(vout_i),
        .word_a_i(word_a_i), .word_b_i(word_b_i), .mem_valid_o(mem_valid_o),
        .mem_addr_o(mem_addr_o), .mem_data_o(mem_data_o), .mem_ready_i(mem_ready_i),
        .last_dma_o(last_dma_o), .vtx_count_o(vtx_count_o), .error_o(error_o),
        .irq_o(irq_o)
    );

    always @(posedge clk) if (rst_n && irq_o) irq_cnt <= irq_cnt + 1;

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] swap_bytes(input logic [DATA_W-1:0] w);
        return {w[7:0], w[15:8], w[23:16], w[31:24]};
    endfunction

    function automatic logic [ADDR_W-1:0] vtx_addr(input logic [ADDR_W-1:0] b,
                                                   input int x, input int y);
        return b + ADDR_W'(8 * (128 * y + x));
    endfunction

    task automatic write_word(input logic [ADDR_W-1:0] ea, input logic [DATA_W-1:0] w,
                              input int stall);
        for (int k = 0; k < stall; k++) begin
            chk(mem_valid_o == 1'b1, "R7 valid held", 64'(mem_valid_o), 64'd1);
            chk(mem_addr_o == ea, "R7 addr held", 64'(mem_addr_o), 64'(ea));
            tick;
        end
        chk(mem_valid_o == 1'b1, "R7 valid", 64'(mem_valid_o), 64'd1);
        chk(mem_addr_o == ea, "R5 address", 64'(mem_addr_o), 64'(ea));
        chk(mem_data_o == swap_bytes(w), "R6 byte order", 64'(mem_data_o),
            64'(swap_bytes(w)));
        mem_ready_i = 1'b1;
        tick;
        mem_ready_i = 1'b0;
    endtask

    // steps < 0 picks a random count below the watchdog limit
    task automatic run_mesh(input int hl, input int vl, input logic [ADDR_W-1:0] base,
                            input bit poke, input int steps);
        int irq_before = irq_cnt;
        base_i  = base;
        hlast_i = IDX_W'(hl);
        vlast_i = IDX_W'(vl);
        start_i = 1'b1;
        tick;
        start_i = 1'b0;
        // R2: the captured values must be used, not these
        base_i  = ADDR_W'($urandom);
        hlast_i = IDX_W'($urandom);
        vlast_i = IDX_W'($urandom);
        chk(busy_o == 1'b1, "R1 busy after start", 64'(busy_o), 64'd1);
        chk(error_o == 1'b0, "R9 error cleared by start", 64'(error_o), 64'd0);
        for (int y = 0; y <= vl; y++) begin
            for (int x = 0; x <= hl; x++) begin
                int n;
                logic [DATA_W-1:0] wa, wb;
                chk(pc_clear_o == 1'b1, "R4 pc clear", 64'(pc_clear_o), 64'd1);
                chk(coord_x_o == IDX_W'(x) && coord_y_o == IDX_W'(y), "R3 order",
                    64'({coord_y_o, coord_x_o}), 64'({IDX_W'(y), IDX_W'(x)}));
                tick;
                chk(exec_run_o == 1'b1 && pc_clear_o == 1'b0, "R4 run follows clear",
                    64'({exec_run_o, pc_clear_o}), 64'b10);
                n = (steps < 0) ? int'($urandom_range(0, MAX_INSNS - 2)) : steps;
                for (int s = 0; s < n; s++) begin
                    exec_step_i = 1'b1;
                    if (poke && s == 0) start_i = 1'b1;
                    tick;
                    start_i = 1'b0;
                end
                exec_step_i = 1'b0;
                if (poke && n == 0) begin
                    start_i = 1'b1;
                    tick;
                    start_i = 1'b0;
                end
                chk(exec_run_o == 1'b1, "R9 no early abort", 64'(exec_run_o), 64'd1);
                wa = $urandom;
                wb = $urandom;
                vout_i = 1'b1;
                word_a_i = wa;
                word_b_i = wb;
                tick;
                vout_i = 1'b0;
                word_a_i = $urandom;
                word_b_i = $urandom;
                write_word(vtx_addr(base, x, y), wa, int'($urandom_range(0, 3)));
                write_word(vtx_addr(base, x, y) + 4, wb, int'($urandom_range(0, 3)));
                chk(last_dma_o == vtx_addr(base, x, y) + 4, "R8 last write",
                    64'(last_dma_o), 64'(vtx_addr(base, x, y) + 4));
                chk(mem_valid_o == 1'b0, "R7 valid drops", 64'(mem_valid_o), 64'd0);
                tick;
            end
        end
        chk(irq_o == 1'b1, "R10 irq", 64'(irq_o), 64'd1);
        tick;
        chk(irq_o == 1'b0 && busy_o == 1'b0, "R10 irq single, R1 idle",
            64'({irq_o, busy_o}), 64'd0);
        chk(vtx_count_o == CNT_W'((hl + 1) * (vl + 1)), "R10 vertex count",
            64'(vtx_count_o), 64'((hl + 1) * (vl + 1)));
        chk(irq_cnt == irq_before + 1, "R10 one pulse", 64'(irq_cnt),
            64'(irq_before + 1));
    endtask

    task automatic run_abort(input logic [ADDR_W-1:0] base);
        int irq_before = irq_cnt;
        logic [CNT_W-1:0] cnt_before = vtx_count_o;
        base_i  = base;
        hlast_i = IDX_W'(2);
        vlast_i = IDX_W'(1);
        start_i = 1'b1;
        tick;
        start_i = 1'b0;
        tick;
        for (int s = 0; s < MAX_INSNS; s++) begin
            exec_step_i = 1'b1;
            tick;
        end
        exec_step_i = 1'b0;
        chk(busy_o == 1'b0 && exec_run_o == 1'b0, "R9 abort ends run",
            64'({busy_o, exec_run_o}), 64'd0);
        chk(error_o == 1'b1, "R9 error flag", 64'(error_o), 64'd1);
        tick;
        chk(irq_cnt == irq_before, "R9 no irq on abort", 64'(irq_cnt), 64'(irq_before));
        chk(vtx_count_o == cnt_before, "R9 count kept", 64'(vtx_count_o),
            64'(cnt_before));
        chk(mem_valid_o == 1'b0, "R9 no write", 64'(mem_valid_o), 64'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        tick;
        chk(busy_o == 1'b0 && irq_o == 1'b0 && mem_valid_o == 1'b0, "R1 reset outputs",
            64'({busy_o, irq_o, mem_valid_o}), 64'd0);
        chk(error_o == 1'b0 && vtx_count_o == '0 && last_dma_o == '0, "R1 reset status",
            64'({error_o, vtx_count_o, last_dma_o}), 64'd0);
        rst_n = 1'b1;
        tick;
        // R2: start strobe stays low here; nothing should happen
        chk(busy_o == 1'b0, "R1 idle without start", 64'(busy_o), 64'd0);

        run_mesh(0, 0, 32'h0001_0000, 1'b0, 0);
        run_mesh(2, 1, 32'h0040_0000, 1'b1, -1);
        run_mesh(1, 2, 32'h8000_1000, 1'b0, MAX_INSNS - 1);
        run_mesh(15, 0, 32'h0000_0008, 1'b0, 0);
        for (int r = 0; r < 5; r++) begin
            run_mesh(int'($urandom_range(0, 4)), int'($urandom_range(0, 3)),
                     {$urandom, 3'b000}, r[0], -1);
        end
        run_abort(32'h0002_0000);
        run_mesh(1, 1, 32'h0003_0000, 1'b1, -1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG_LIMIT) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule